// File: doc/BRIEF.md
# Memory Bank Select Decoder

This block sits in front of a memory controller. For each access it decides which of twelve memory banks the address belongs to. Each bank holds its own set of settings: base address, size mask, port width, controller machine, target bus, error-protection mode, read-only flag, pipelining flag and external-controller flag. One cycle after an access strobe, the block reports its result. On a hit, it drives a one-hot chip select and the settings of the winning bank. It also tells the controller whether an internal machine should start. An access that matches no bank is reported as a miss. A write to a protected bank is refused.

The bank settings are loaded through a single-cycle write port. For every enabled bank, the block checks continuously whether the settings are legal for the chosen machine. The rules cover size bounds for the synchronous DRAM machine, port widths that can carry check bits, and a strict-bus input that some parity settings need. A bank whose settings are illegal raises its configuration-error flag and takes part in no decode. After reset only bank 0 is enabled. It covers the whole address space as a 16-bit general-purpose bank on the system bus, so that boot code can be fetched.

Top module: `bank_route_dec`

## Requirements
- R1: After reset every response output and every configuration-error flag is 0. Bank 0 is enabled with base 0, mask 0, machine 0 (general purpose), system bus (bus bit 0), port code 1, protection 0, and read-only, pipelining and external flags all 0. Banks 1 to 11 are disabled, so any system-bus access hits bank 0.
- R2: A write with `cfg_we` high loads `cfg_wdata` into bank `cfg_bank`, and a bank number of 12 or more is ignored. The field positions are: [45] enable, [44:28] base, [27:11] mask, [10:8] machine, [7] bus (0 system, 1 local), [6:5] port (0=8, 1=16, 2=32, 3=64 bits), [4:3] protection (0 none, 1 plain parity, 2 read-modify-write parity, 3 ECC), [2] read-only, [1] pipelining, [0] external.
- R3: A bank matches when all of these hold: it is enabled, it has no configuration error, its bus bit equals `acc_lbus`, and `acc_addr[31:15]` equals its base in every bit where its mask is 1.
- R4: When several banks match, the lowest-numbered bank wins, and at most one chip-select bit is ever high.
- R5: A valid access that matches no bank gives `rsp_nohit`=1, with all chip selects at 0 and `rsp_start` at 0.
- R6: The response appears in the cycle after `acc_valid`, and `rsp_valid` copies it. When `rsp_valid` is 0, every other response output is 0. On a hit, the machine, bus, port, protection, pipelining and external outputs carry the winning bank's fields.
- R7: A write that wins on a read-only bank gives `rsp_wp_err`=1, with the chip select and `rsp_start` held at 0. A read of that bank proceeds normally.
- R8: With the machine set to 4 (synchronous DRAM), the count of 0 bits in the mask must be between 5 and 12 (1 MB to 128 MB). Outside that range the bank's `cfg_err` bit is set. Other machines accept any mask.
- R9: Protection 3 (ECC) on a port other than 64 bits sets the bank's `cfg_err`.
- R10: Protection 2 sets `cfg_err` on an 8-bit or 16-bit port. It also sets `cfg_err` on a 32-bit port while `strict_mode` is 0.
- R11: A machine code of 5, 6 or 7 sets the bank's `cfg_err`. `cfg_err` shows the enabled banks' legality one cycle after the settings or `strict_mode` change. A disabled bank never flags.
- R12: `rsp_start` is 1 only on a permitted hit to a bank whose external flag is 0. The external flag itself is passed out on `rsp_ext`.
- R13: A bank with its `cfg_err` set never asserts its chip select, and the access goes to the next matching bank or to a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Settings write strobe |
| cfg_bank | input | 4 | Bank number being written |
| cfg_wdata | input | 46 | Packed bank settings |
| strict_mode | input | 1 | Strict-bus mode, permits read-modify-write parity on 32-bit ports |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | 1 for a write access |
| acc_lbus | input | 1 | 1 when the access comes from the local bus |
| rsp_valid | output | 1 | Response present |
| rsp_cs | output | 12 | One-hot chip select |
| rsp_nohit | output | 1 | Access matched no bank |
| rsp_wp_err | output | 1 | Write refused by a read-only bank |
| rsp_start | output | 1 | Internal machine should run the access |
| rsp_mach | output | 3 | Machine code of the winning bank |
| rsp_lbus | output | 1 | Bus of the winning bank |
| rsp_psize | output | 2 | Port width code of the winning bank |
| rsp_prot | output | 2 | Protection mode of the winning bank |
| rsp_pipe | output | 1 | Pipelining flag of the winning bank |
| rsp_ext | output | 1 | External-controller flag of the winning bank |
| cfg_err | output | 12 | Per-bank illegal-settings flags |

## Verification
The assertions assume that `acc_valid` is held low during reset. They also assume that a settings write and an access are never issued in the same cycle. If they were, the response would reflect the older settings, while `cfg_err` and the chip select would be registered from the same snapshot. The stimulus keeps to both rules: settings writes and accesses are issued in separate cycles, and all inputs are driven on the falling edge. The assertions that relate `cfg_err` to the chip select rely on both outputs being registered from the same settings in the same cycle.

// File: rtl/bank_route_pkg.sv
// Shared constants and types for the bank select decoder.
// Assumes a 32-bit address, of which the top CMP_W bits are decoded.
package bank_route_pkg;
    localparam int ADDR_W        = 32;
    localparam int CMP_W         = 17;
    localparam int ZCNT_W        = $clog2(CMP_W + 1);
    localparam int SDR_MIN_ZEROS = 5;
    localparam int SDR_MAX_ZEROS = 12;

    localparam logic [2:0] MACH_GP     = 3'd0;
    localparam logic [2:0] MACH_PROG_A = 3'd1;
    localparam logic [2:0] MACH_PROG_B = 3'd2;
    localparam logic [2:0] MACH_PROG_C = 3'd3;
    localparam logic [2:0] MACH_SDR    = 3'd4;

    localparam logic [1:0] PSZ_8  = 2'd0;
    localparam logic [1:0] PSZ_16 = 2'd1;
    localparam logic [1:0] PSZ_32 = 2'd2;
    localparam logic [1:0] PSZ_64 = 2'd3;

    localparam logic [1:0] PROT_NONE = 2'd0;
    localparam logic [1:0] PROT_PAR  = 2'd1;
    localparam logic [1:0] PROT_RMW  = 2'd2;
    localparam logic [1:0] PROT_ECC  = 2'd3;

    typedef struct packed {
        logic             valid;
        logic [CMP_W-1:0] base;
        logic [CMP_W-1:0] mask;
        logic [2:0]       mach;
        logic             lbus;
        logic [1:0]       psize;
        logic [1:0]       prot;
        logic             ro;
        logic             pipe;
        logic             ext;
    } bank_cfg_t;

    localparam int CFG_W = $bits(bank_cfg_t);

    localparam bank_cfg_t BOOT_CFG = '{valid: 1'b1, base: '0, mask: '0,
        mach: MACH_GP, lbus: 1'b0, psize: PSZ_16, prot: PROT_NONE,
        ro: 1'b0, pipe: 1'b0, ext: 1'b0};
    localparam bank_cfg_t IDLE_CFG = '0;
endpackage

// File: rtl/bank_cfg_regs.sv
// Settings storage for all banks.
// Bank 0 resets to the boot window; the others reset disabled.
// Writes to a bank number beyond NUM_BANKS are dropped.
module bank_cfg_regs
    import bank_route_pkg::*;
#(
    parameter int NUM_BANKS = 12,
    parameter int IDX_W     = $clog2(NUM_BANKS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [IDX_W-1:0]            wbank,
    input  bank_cfg_t                   wdata,
    output bank_cfg_t [NUM_BANKS-1:0]   cfg
);
    // Hold per-bank settings; load one bank per write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NUM_BANKS; b++)
                cfg[b] <= (b == 0) ? BOOT_CFG : IDLE_CFG;
        end else if (we && (int'(wbank) < NUM_BANKS)) begin
            cfg[wbank] <= wdata;
        end
    end
endmodule

// File: rtl/bank_match.sv
// One bank's legality check and address compare.
// Assumes cfg is stable for the cycle. The mask is counted, not checked for contiguity.
module bank_match
    import bank_route_pkg::*;
(
    input  bank_cfg_t        cfg,
    input  logic [CMP_W-1:0] addr_hi,
    input  logic             acc_lbus,
    input  logic             strict,
    output logic             hit,
    output logic             bad
);
    logic [ZCNT_W-1:0] zeros;

    // Count the mask's zero bits, which give the block size above 32 KB.
    always_comb begin
        zeros = '0;
        for (int k = 0; k < CMP_W; k++)
            zeros = zeros + ZCNT_W'(!cfg.mask[k]);
    end

    // Flag settings that the chosen machine and port cannot support.
    always_comb begin
        bad = 1'b0;
        if (cfg.valid) begin
            if (cfg.mach > MACH_SDR)
                bad = 1'b1;
            if (cfg.mach == MACH_SDR &&
                (zeros < ZCNT_W'(SDR_MIN_ZEROS) || zeros > ZCNT_W'(SDR_MAX_ZEROS)))
                bad = 1'b1;
            if (cfg.prot == PROT_ECC && cfg.psize != PSZ_64)
                bad = 1'b1;
            if (cfg.prot == PROT_RMW &&
                (cfg.psize == PSZ_8 || cfg.psize == PSZ_16 ||
                 (cfg.psize == PSZ_32 && !strict)))
                bad = 1'b1;
        end
    end

    // Compare the masked upper address against the base on the bank's own bus.
    always_comb begin
        hit = cfg.valid && !bad && (cfg.lbus == acc_lbus) &&
              (((addr_hi ^ cfg.base) & cfg.mask) == '0);
    end
endmodule

// File: rtl/bank_pick.sv
// Priority pick among matching banks: the lowest index wins.
// idx is 0 when nothing matches.
module bank_pick #(
    parameter int NUM_BANKS = 12,
    parameter int IDX_W     = $clog2(NUM_BANKS)
) (
    input  logic [NUM_BANKS-1:0] hits,
    output logic                 any,
    output logic [IDX_W-1:0]     idx
);
    // Scan from the top so that the lowest matching bank is the last written.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            if (hits[b]) begin
                any = 1'b1;
                idx = IDX_W'(b);
            end
        end
    end

    // Check that the chosen bank matched and that no lower bank did.
    always_comb begin
        if (any) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (b < int'(idx))
                    assert_pick_lowest_R4: assert (!hits[b]);
            end
            assert_pick_matched_R4: assert (hits[idx]);
        end
    end
endmodule

// File: rtl/bank_route_dec.sv
// Top of the bank select decoder. Decodes an access against every bank,
// picks the winner and registers the response one cycle after acc_valid.
// Assumes settings writes and accesses do not share a cycle.
module bank_route_dec
    import bank_route_pkg::*;
#(
    parameter int NUM_BANKS = 12,
    parameter int IDX_W     = $clog2(NUM_BANKS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [IDX_W-1:0]      cfg_bank,
    input  logic [CFG_W-1:0]      cfg_wdata,
    input  logic                  strict_mode,
    input  logic                  acc_valid,
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic                  acc_write,
    input  logic                  acc_lbus,
    output logic                  rsp_valid,
    output logic [NUM_BANKS-1:0]  rsp_cs,
    output logic                  rsp_nohit,
    output logic                  rsp_wp_err,
    output logic                  rsp_start,
    output logic [2:0]            rsp_mach,
    output logic                  rsp_lbus,
    output logic [1:0]            rsp_psize,
    output logic [1:0]            rsp_prot,
    output logic                  rsp_pipe,
    output logic                  rsp_ext,
    output logic [NUM_BANKS-1:0]  cfg_err
);
    bank_cfg_t [NUM_BANKS-1:0] cfg;
    logic [NUM_BANKS-1:0]      hits;
    logic [NUM_BANKS-1:0]      bad;
    logic                      any;
    logic [IDX_W-1:0]          idx;
    bank_cfg_t                 win;
    logic                      wp;

    bank_cfg_regs #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wbank (cfg_bank),
        .wdata (bank_cfg_t'(cfg_wdata)),
        .cfg   (cfg)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_match
        bank_match u_match (
            .cfg      (cfg[g]),
            .addr_hi  (acc_addr[ADDR_W-1 -: CMP_W]),
            .acc_lbus (acc_lbus),
            .strict   (strict_mode),
            .hit      (hits[g]),
            .bad      (bad[g])
        );
    end

    bank_pick #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) u_pick (
        .hits (hits),
        .any  (any),
        .idx  (idx)
    );

    // Select the winning bank's settings and test for a protected write.
    always_comb begin
        win = cfg[idx];
        wp  = acc_write && win.ro;
    end

    // Register the response and the per-bank legality flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_cs     <= '0;
            rsp_nohit  <= 1'b0;
            rsp_wp_err <= 1'b0;
            rsp_start  <= 1'b0;
            rsp_mach   <= '0;
            rsp_lbus   <= 1'b0;
            rsp_psize  <= '0;
            rsp_prot   <= '0;
            rsp_pipe   <= 1'b0;
            rsp_ext    <= 1'b0;
            cfg_err    <= '0;
        end else begin
            cfg_err   <= bad;
            rsp_valid <= acc_valid;
            if (acc_valid && any) begin
                rsp_cs     <= wp ? '0 : (NUM_BANKS'(1) << idx);
                rsp_nohit  <= 1'b0;
                rsp_wp_err <= wp;
                rsp_start  <= !wp && !win.ext;
                rsp_mach   <= win.mach;
                rsp_lbus   <= win.lbus;
                rsp_psize  <= win.psize;
                rsp_prot   <= win.prot;
                rsp_pipe   <= win.pipe;
                rsp_ext    <= win.ext;
            end else begin
                rsp_cs     <= '0;
                rsp_nohit  <= acc_valid;
                rsp_wp_err <= 1'b0;
                rsp_start  <= 1'b0;
                rsp_mach   <= '0;
                rsp_lbus   <= 1'b0;
                rsp_psize  <= '0;
                rsp_prot   <= '0;
                rsp_pipe   <= 1'b0;
                rsp_ext    <= 1'b0;
            end
        end
    end

    assert_cs_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_cs));
    assert_nohit_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_nohit |-> (rsp_cs == '0 && !rsp_start && !rsp_wp_err));
    assert_rsp_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(acc_valid));
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_cs == '0 && !rsp_nohit && !rsp_wp_err && !rsp_start));
    assert_wp_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_wp_err |-> (rsp_cs == '0 && !rsp_start && $past(acc_write)));
    assert_start_internal_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_start |-> (!rsp_ext && rsp_cs != '0));
    assert_bad_bank_silent_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_cs & cfg_err) == '0);
endmodule

// File: tb/tb_bank_route_dec.sv
module tb_bank_route_dec;
    localparam int NB = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_bank = '0;
    logic [45:0] cfg_wdata = '0;
    logic        strict_mode = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        acc_lbus = 1'b0;
    logic        rsp_valid, rsp_nohit, rsp_wp_err, rsp_start, rsp_lbus, rsp_pipe, rsp_ext;
    logic [NB-1:0] rsp_cs, cfg_err;
    logic [2:0]  rsp_mach;
    logic [1:0]  rsp_psize, rsp_prot;

    bank_route_dec dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
        .cfg_wdata(cfg_wdata), .strict_mode(strict_mode), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_write(acc_write), .acc_lbus(acc_lbus),
        .rsp_valid(rsp_valid), .rsp_cs(rsp_cs), .rsp_nohit(rsp_nohit),
        .rsp_wp_err(rsp_wp_err), .rsp_start(rsp_start), .rsp_mach(rsp_mach),
        .rsp_lbus(rsp_lbus), .rsp_psize(rsp_psize), .rsp_prot(rsp_prot),
        .rsp_pipe(rsp_pipe), .rsp_ext(rsp_ext), .cfg_err(cfg_err)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit live = 0;
    bit done = 0;
    string tag = "R1";

    // Behavioural model state: one entry per bank.
    int m_valid[NB], m_base[NB], m_mask[NB], m_mach[NB], m_lbus[NB];
    int m_psize[NB], m_prot[NB], m_ro[NB], m_pipe[NB], m_ext[NB];

    logic          e_valid, e_nohit, e_wp, e_start, e_lbus, e_pipe, e_ext;
    logic [NB-1:0] e_cs, e_cerr;
    logic [2:0]    e_mach;
    logic [1:0]    e_psize, e_prot;

    function automatic bit m_bad(int i, bit strict);
        int zeros = 0;
        if (m_valid[i] == 0) return 0;
        for (int k = 0; k < 17; k++)
            if (((m_mask[i] >> k) & 1) == 0) zeros++;
        if (m_mach[i] > 4) return 1;
        if (m_mach[i] == 4 && (zeros < 5 || zeros > 12)) return 1;
        if (m_prot[i] == 3 && m_psize[i] != 3) return 1;
        if (m_prot[i] == 2 && m_psize[i] < 2) return 1;
        if (m_prot[i] == 2 && m_psize[i] == 2 && !strict) return 1;
        return 0;
    endfunction

    task automatic m_reset();
        for (int i = 0; i < NB; i++) begin
            m_valid[i] = 0; m_base[i] = 0; m_mask[i] = 0; m_mach[i] = 0; m_lbus[i] = 0;
            m_psize[i] = 0; m_prot[i] = 0; m_ro[i] = 0; m_pipe[i] = 0; m_ext[i] = 0;
        end
        m_valid[0] = 1;
        m_psize[0] = 1;
    endtask

    // Reference model: computes the registered response for the next cycle.
    always @(posedge clk) begin
        int win;
        int hi;
        cycles++;
        live = 1;
        e_valid = 0; e_cs = '0; e_nohit = 0; e_wp = 0; e_start = 0; e_mach = '0;
        e_lbus = 0; e_psize = '0; e_prot = '0; e_pipe = 0; e_ext = 0;
        if (!rst_n) begin
            m_reset();
            e_cerr = '0;
        end else begin
            for (int i = 0; i < NB; i++) e_cerr[i] = m_bad(i, strict_mode);
            e_valid = acc_valid;
            if (acc_valid) begin
                win = -1;
                hi = int'(acc_addr >> 15);
                for (int i = 0; i < NB; i++)
                    if (win < 0 && m_valid[i] != 0 && !m_bad(i, strict_mode) &&
                        m_lbus[i] == int'(acc_lbus) && (((hi ^ m_base[i]) & m_mask[i]) == 0))
                        win = i;
                if (win < 0) e_nohit = 1;
                else begin
                    e_wp = acc_write && (m_ro[win] != 0);
                    e_cs = e_wp ? '0 : (NB'(1) << win);
                    e_start = !e_wp && (m_ext[win] == 0);
                    e_mach = 3'(m_mach[win]); e_lbus = 1'(m_lbus[win]);
                    e_psize = 2'(m_psize[win]); e_prot = 2'(m_prot[win]);
                    e_pipe = 1'(m_pipe[win]); e_ext = 1'(m_ext[win]);
                end
            end
            if (cfg_we && cfg_bank < 4'(NB)) begin
                m_valid[cfg_bank] = int'(cfg_wdata[45]);
                m_base[cfg_bank]  = int'(cfg_wdata[44:28]);
                m_mask[cfg_bank]  = int'(cfg_wdata[27:11]);
                m_mach[cfg_bank]  = int'(cfg_wdata[10:8]);
                m_lbus[cfg_bank]  = int'(cfg_wdata[7]);
                m_psize[cfg_bank] = int'(cfg_wdata[6:5]);
                m_prot[cfg_bank]  = int'(cfg_wdata[4:3]);
                m_ro[cfg_bank]    = int'(cfg_wdata[2]);
                m_pipe[cfg_bank]  = int'(cfg_wdata[1]);
                m_ext[cfg_bank]   = int'(cfg_wdata[0]);
            end
        end
    end

    // Compare the design against the model in the middle of every cycle.
    always @(negedge clk) begin
        if (live && !done) begin
            checks++;
            if ({rsp_valid, rsp_cs, rsp_nohit, rsp_wp_err, rsp_start, rsp_mach, rsp_lbus,
                 rsp_psize, rsp_prot, rsp_pipe, rsp_ext} !==
                {e_valid, e_cs, e_nohit, e_wp, e_start, e_mach, e_lbus,
                 e_psize, e_prot, e_pipe, e_ext}) begin
                fails++;
                $display("FAIL %s response: got v%0b cs%03h nh%0b wp%0b st%0b m%0d b%0b p%0d e%0d pl%0b x%0b, exp v%0b cs%03h nh%0b wp%0b st%0b m%0d b%0b p%0d e%0d pl%0b x%0b",
                    tag, rsp_valid, rsp_cs, rsp_nohit, rsp_wp_err, rsp_start, rsp_mach, rsp_lbus,
                    rsp_psize, rsp_prot, rsp_pipe, rsp_ext, e_valid, e_cs, e_nohit, e_wp,
                    e_start, e_mach, e_lbus, e_psize, e_prot, e_pipe, e_ext);
            end
            checks++;
            if (cfg_err !== e_cerr) begin
                fails++;
                $display("FAIL %s cfg_err: got %03h exp %03h", tag, cfg_err, e_cerr);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cycles > 50000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: got %0d cycles exp under 50000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic wcfg(input int bank, input bit v, input logic [16:0] base,
                        input logic [16:0] mask, input logic [2:0] mach, input bit lb,
                        input logic [1:0] psz, input logic [1:0] prot, input bit ro,
                        input bit pipe, input bit ext);
        cfg_we = 1; cfg_bank = 4'(bank);
        cfg_wdata = {v, base, mask, mach, lb, psz, prot, ro, pipe, ext};
        @(negedge clk);
        cfg_we = 0;
        @(negedge clk);
    endtask

    task automatic access(input logic [31:0] a, input bit wr, input bit lb);
        acc_valid = 1; acc_addr = a; acc_write = wr; acc_lbus = lb;
        @(negedge clk);
        acc_valid = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        tag = "R1";
        idle(1);
        rst_n = 1;
        idle(2);
        access(32'h1234_5678, 0, 0);
        access(32'hFFFF_0000, 1, 0);
        idle(2);
        tag = "R5";
        access(32'h0000_1000, 0, 1);
        idle(1);
        tag = "R4";
        wcfg(3, 1, 17'h10000, 17'h1FFE0, 3'd4, 0, 2'd3, 2'd3, 0, 0, 0);
        access(32'h8000_1234, 0, 0);
        idle(1);
        tag = "R3";
        wcfg(0, 1, 17'h00000, 17'h1FF00, 3'd0, 0, 2'd1, 2'd0, 0, 0, 0);
        access(32'h8000_1234, 0, 0);
        access(32'h0070_0000, 1, 0);
        tag = "R5";
        access(32'h0090_0000, 0, 0);
        access(32'h8010_0000, 0, 0);
        idle(1);
        tag = "R2";
        wcfg(11, 1, 17'h00100, 17'h1FFFF, 3'd1, 1, 2'd0, 2'd1, 0, 1, 0);
        wcfg(13, 1, 17'h00000, 17'h00000, 3'd2, 1, 2'd2, 2'd0, 0, 0, 0);
        access(32'h0080_4000, 0, 1);
        access(32'h0000_0000, 0, 1);
        idle(1);
        tag = "R7";
        wcfg(5, 1, 17'h00200, 17'h1FFFF, 3'd2, 1, 2'd2, 2'd1, 1, 0, 0);
        access(32'h0100_0010, 1, 1);
        access(32'h0100_0010, 0, 1);
        idle(1);
        tag = "R12";
        wcfg(6, 1, 17'h00300, 17'h1FFFF, 3'd3, 0, 2'd2, 2'd0, 0, 1, 1);
        access(32'h0180_0000, 0, 0);
        idle(1);
        tag = "R8";
        wcfg(7, 1, 17'h00400, 17'h1FFFF, 3'd4, 0, 2'd3, 2'd0, 0, 0, 0);
        tag = "R13";
        access(32'h0200_0000, 0, 0);
        tag = "R8";
        wcfg(7, 1, 17'h00400, 17'h1F000, 3'd4, 0, 2'd3, 2'd0, 0, 0, 0);
        access(32'h0200_0000, 0, 0);
        wcfg(7, 1, 17'h00400, 17'h1E000, 3'd4, 0, 2'd3, 2'd0, 0, 0, 0);
        access(32'h0200_0000, 0, 0);
        idle(1);
        tag = "R9";
        wcfg(8, 1, 17'h00500, 17'h1FFFF, 3'd0, 0, 2'd2, 2'd3, 0, 0, 0);
        access(32'h0280_0000, 0, 0);
        wcfg(8, 1, 17'h00500, 17'h1FFFF, 3'd0, 0, 2'd3, 2'd3, 0, 0, 0);
        access(32'h0280_0000, 0, 0);
        idle(1);
        tag = "R10";
        wcfg(9, 1, 17'h00600, 17'h1FFFF, 3'd1, 0, 2'd1, 2'd2, 0, 0, 0);
        access(32'h0300_0000, 0, 0);
        wcfg(9, 1, 17'h00600, 17'h1FFFF, 3'd1, 0, 2'd2, 2'd2, 0, 0, 0);
        access(32'h0300_0000, 0, 0);
        strict_mode = 1;
        idle(2);
        access(32'h0300_0000, 0, 0);
        strict_mode = 0;
        wcfg(9, 1, 17'h00600, 17'h1FFFF, 3'd1, 0, 2'd3, 2'd2, 0, 0, 0);
        access(32'h0300_0000, 0, 0);
        idle(1);
        tag = "R11";
        wcfg(10, 1, 17'h00700, 17'h1FFFF, 3'd6, 0, 2'd0, 2'd0, 0, 0, 0);
        access(32'h0380_0000, 0, 0);
        wcfg(10, 0, 17'h00700, 17'h1FFFF, 3'd6, 0, 2'd0, 2'd0, 0, 0, 0);
        idle(2);
        tag = "R6";
        for (int i = 0; i < 8; i++) access(32'h0000_0000 + 32'(i) * 32'h0080_0000, i[0], 0);
        idle(3);
        tag = "R3";
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            a = {4'(0), 5'($urandom_range(0, 8)), 23'($urandom)};
            if ($urandom_range(0, 3) == 0) a[31] = 1'b1;
            if ($urandom_range(0, 20) == 0) strict_mode = ~strict_mode;
            if ($urandom_range(0, 4) == 0) idle(1);
            access(a, 1'($urandom), 1'($urandom));
        end
        idle(3);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule